// File: doc/BRIEF.md
# Converter Control Register Bank with Calibration Lockout

This block holds the control registers of a dual-channel analog-to-digital converter. It is fed by a serial write port that has already been decoded into an address, a data word and a write strobe. The block turns the stored register contents into the effective mode outputs and the compensation trims that the converter datapath uses.

A start input begins an auto-calibration phase, and a done input ends it. While calibration runs, the block drives a fixed operating configuration on its mode outputs and drops every register write. When calibration ends, the stored user settings return to the outputs.

The offset trim and the gain trim can only be written in manual mode. Manual mode is selected by clearing the two calibration-select bits of the mode register. The gain trim only matters when both channels are in use. In single-channel operation the gain output shows the neutral value.

Top module: `cal_lock_ctrl`

## Requirements
- R1: After reset, the block is in this state: calibration idle, offset and gain trims at the neutral value 128, and the mode register at 0x0C02. The outputs then read decim_o=0, dmux_sel_o=01, gray_o=0 and manual_o=0.
- R2: cal_start_i sampled high while idle sets cal_busy_o on the next cycle. cal_busy_o stays high until cal_done_i is sampled high. A further start while busy has no effect.
- R3: cal_done_i sampled high while busy clears cal_busy_o on the next cycle. The outputs then show the stored mode settings again.
- R4: While cal_busy_o is high, the outputs are forced to decim_o=1, dmux_sel_o=00 (1:1) and gray_o=0 (binary), whatever the mode register holds.
- R5: A write sampled while cal_busy_o is high is discarded. No stored register changes.
- R6: Address 000 is the mode register, written with the whole 16-bit word. Its fields are: bit 0 decimation, bits 2:1 demux select, bit 3 Gray coding, bit 4 single channel, and bits 11:10 calibration select. A calibration-select value of 00 means manual mode (manual_o=1). Outside calibration, the outputs show a write on the next cycle.
- R7: Address 010 is the offset trim, taken from data bits 7:0 and shown on offset_o. The write only takes effect while the stored calibration-select bits are 00.
- R8: Address 011 is the gain trim, taken from data bits 7:0 under the same manual-mode gating. gain_o shows the stored trim, or 128 when the single-channel bit is set.
- R9: Writes to addresses 001 and 100 through 111 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Decoded write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Write data |
| cal_start_i | input | 1 | Begin calibration |
| cal_done_i | input | 1 | Calibration finished |
| cal_busy_o | output | 1 | Calibration in progress |
| decim_o | output | 1 | Effective decimation enable |
| dmux_sel_o | output | 2 | Effective demux ratio select |
| gray_o | output | 1 | Effective output coding (1 = Gray) |
| manual_o | output | 1 | Manual compensation mode selected |
| offset_o | output | 8 | Offset trim |
| gain_o | output | 8 | Effective gain trim |

## Verification
The bench targets four corner cases:
- A write in the same cycle as the start pulse must still land. A write in the same cycle as the done pulse must be dropped. A design with the lock off by one cycle would get one of these wrong.
- Trim writes are sent while the calibration-select bits are non-zero. A design that ignores the manual gate would move offset_o or gain_o.
- The single-channel bit is toggled with a non-neutral gain stored. A design that clears the trim instead of masking it would lose the value when the bit is cleared.
- Writes are sent during calibration with values that differ from the forced configuration. This catches a design that stores them, or that leaves the forced values on the outputs after done.

// File: rtl/cal_lock_pkg.sv
package cal_lock_pkg;
  typedef enum logic [2:0] {
    ADDR_MODE = 3'b000,
    ADDR_OFFS = 3'b010,
    ADDR_GAIN = 3'b011
  } reg_addr_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CAL  = 1'b1
  } cal_state_e;

  // mode register bit positions, decoded by the output stage
  localparam int unsigned BIT_DECIM  = 0;
  localparam int unsigned BIT_DMUX_L = 1;
  localparam int unsigned BIT_GRAY   = 3;
  localparam int unsigned BIT_SINGLE = 4;
  localparam int unsigned BIT_CSEL_L = 10;
  localparam int unsigned BIT_CSEL_H = 11;
endpackage

// File: rtl/cal_fsm.sv
module cal_fsm
  import cal_lock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);
  cal_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CAL;
      ST_CAL:  if (done_i)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign busy_o = (state_q == ST_CAL);

  AST_START_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> busy_o); // R2
  AST_DONE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i) |=> !busy_o); // R3
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cal_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CMP_W  = 8,
  parameter logic [DATA_W-1:0] MODE_RST = 16'h0C02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              lock_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [CMP_W-1:0]  offs_o,
  output logic [CMP_W-1:0]  gain_o
);
  localparam logic [CMP_W-1:0] CMP_NEUTRAL = CMP_W'(1) << (CMP_W - 1);

  logic [DATA_W-1:0] mode_q;
  logic [CMP_W-1:0]  offs_q, gain_q;
  logic wr_ok, manual, we_mode, we_offs, we_gain;

  assign wr_ok   = wr_en_i && !lock_i;
  assign manual  = (mode_q[BIT_CSEL_H:BIT_CSEL_L] == 2'b00);
  assign we_mode = wr_ok && (wr_addr_i == ADDR_MODE);
  assign we_offs = wr_ok && manual && (wr_addr_i == ADDR_OFFS);
  assign we_gain = wr_ok && manual && (wr_addr_i == ADDR_GAIN);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mode_q <= MODE_RST;
    else if (we_mode) mode_q <= wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) offs_q <= CMP_NEUTRAL;
    else if (we_offs) offs_q <= wr_data_i[CMP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) gain_q <= CMP_NEUTRAL;
    else if (we_gain) gain_q <= wr_data_i[CMP_W-1:0];

  assign mode_o = mode_q;
  assign offs_o = offs_q;
  assign gain_o = gain_q;

  AST_LOCK_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(mode_q) && $stable(offs_q) && $stable(gain_q))); // R5
  AST_OFFS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_OFFS && mode_q[BIT_CSEL_H:BIT_CSEL_L] != 2'b00)
      |=> $stable(offs_q)); // R7
  AST_GAIN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_GAIN && mode_q[BIT_CSEL_H:BIT_CSEL_L] != 2'b00)
      |=> $stable(gain_q)); // R8
endmodule

// File: rtl/mode_out.sv
module mode_out
  import cal_lock_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CMP_W  = 8
) (
  input  logic              busy_i,
  input  logic [DATA_W-1:0] mode_i,
  input  logic [CMP_W-1:0]  gain_i,
  output logic              decim_o,
  output logic [1:0]        dmux_o,
  output logic              gray_o,
  output logic              manual_o,
  output logic [CMP_W-1:0]  gain_o
);
  localparam logic [CMP_W-1:0] CMP_NEUTRAL = CMP_W'(1) << (CMP_W - 1);

  // forced during calibration: decimation on, 1:1 demux, binary coding
  always_comb begin
    if (busy_i) begin
      decim_o = 1'b1;
      dmux_o  = 2'b00;
      gray_o  = 1'b0;
    end else begin
      decim_o = mode_i[BIT_DECIM];
      dmux_o  = mode_i[BIT_DMUX_L+1:BIT_DMUX_L];
      gray_o  = mode_i[BIT_GRAY];
    end
  end

  assign manual_o = (mode_i[BIT_CSEL_H:BIT_CSEL_L] == 2'b00);
  assign gain_o   = mode_i[BIT_SINGLE] ? CMP_NEUTRAL : gain_i;
endmodule

// File: rtl/cal_lock_ctrl.sv
module cal_lock_ctrl
  import cal_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CMP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cal_start_i,
  input  logic              cal_done_i,
  output logic              cal_busy_o,
  output logic              decim_o,
  output logic [1:0]        dmux_sel_o,
  output logic              gray_o,
  output logic              manual_o,
  output logic [CMP_W-1:0]  offset_o,
  output logic [CMP_W-1:0]  gain_o
);
  logic              busy;
  logic [DATA_W-1:0] mode_w;
  logic [CMP_W-1:0]  gain_w;

  cal_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cal_start_i),
    .done_i  (cal_done_i),
    .busy_o  (busy)
  );

  cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .lock_i    (busy),
    .mode_o    (mode_w),
    .offs_o    (offset_o),
    .gain_o    (gain_w)
  );

  mode_out #(.DATA_W(DATA_W), .CMP_W(CMP_W)) u_out (
    .busy_i   (busy),
    .mode_i   (mode_w),
    .gain_i   (gain_w),
    .decim_o  (decim_o),
    .dmux_o   (dmux_sel_o),
    .gray_o   (gray_o),
    .manual_o (manual_o),
    .gain_o   (gain_o)
  );

  assign cal_busy_o = busy;

  AST_FORCE_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_busy_o |-> (decim_o && dmux_sel_o == 2'b00 && !gray_o)); // R4
  AST_BUSY_OUT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_busy_o |=> ($stable(offset_o) && $stable(manual_o))); // R5
endmodule

// File: tb/sim_cal_lock_ctrl.sv
module sim_cal_lock_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic cal_start = 1'b0, cal_done = 1'b0;
  logic cal_busy, decim, gray, manual;
  logic [1:0] dmux;
  logic [7:0] offset, gain;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";

  // reference model state
  int m_busy, m_mode, m_off, m_gain;

  always #5 clk = ~clk;

  cal_lock_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cal_start_i(cal_start), .cal_done_i(cal_done),
    .cal_busy_o(cal_busy), .decim_o(decim), .dmux_sel_o(dmux), .gray_o(gray),
    .manual_o(manual), .offset_o(offset), .gain_o(gain)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_mode = 'h0C02; m_off = 128; m_gain = 128;
    end else if (m_busy != 0) begin
      if (cal_done) m_busy = 0;
    end else begin
      if (wr_en) begin
        if (wr_addr == 3'd0) m_mode = int'(wr_data);
        else if (wr_addr == 3'd2 && ((m_mode >> 10) & 3) == 0) m_off = int'(wr_data) & 255;
        else if (wr_addr == 3'd3 && ((m_mode >> 10) & 3) == 0) m_gain = int'(wr_data) & 255;
      end
      if (cal_start) m_busy = 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni) begin
      cycles++;
      chk("R2", "busy", int'(cal_busy), m_busy);
      chk(m_busy != 0 ? "R4" : "R6", "decim", int'(decim), m_busy != 0 ? 1 : (m_mode & 1));
      chk(m_busy != 0 ? "R4" : "R6", "dmux", int'(dmux), m_busy != 0 ? 0 : ((m_mode >> 1) & 3));
      chk(m_busy != 0 ? "R4" : "R6", "gray", int'(gray), m_busy != 0 ? 0 : ((m_mode >> 3) & 1));
      chk("R6", "manual", int'(manual), ((m_mode >> 10) & 3) == 0 ? 1 : 0);
      chk("R7", "offset", int'(offset), m_off);
      chk("R8", "gain", int'(gain), ((m_mode >> 4) & 1) != 0 ? 128 : m_gain);
      if (cycles > 5000) begin
        chk("WDOG", "watchdog", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(2);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(cal_busy), 0);
    chk("R1", "offset", int'(offset), 128);
    chk("R1", "gain", int'(gain), 128);
    chk("R1", "dmux", int'(dmux), 1);
    chk("R1", "manual", int'(manual), 0);

    // R7 R8 gated in auto mode
    phase = "R7";
    wr(3'd2, 16'h0099);
    wr(3'd3, 16'h0077);
    idle(1);
    chk("R7", "offset gated", int'(offset), 128);
    chk("R8", "gain gated", int'(gain), 128);

    // R6 manual mode with fields
    wr(3'd0, 16'h000D);
    idle(1);
    chk("R6", "decim", int'(decim), 1);
    chk("R6", "dmux", int'(dmux), 2);
    chk("R6", "gray", int'(gray), 1);
    chk("R6", "manual", int'(manual), 1);

    wr(3'd2, 16'hFF33);
    wr(3'd3, 16'h1250);
    idle(1);
    chk("R7", "offset", int'(offset), 'h33);
    chk("R8", "gain", int'(gain), 'h50);

    // R8 single channel masks gain, keeps stored value
    wr(3'd0, 16'h001D);
    idle(1);
    chk("R8", "gain single", int'(gain), 128);
    wr(3'd0, 16'h000D);
    idle(1);
    chk("R8", "gain restored", int'(gain), 'h50);

    // R9 unused addresses
    wr(3'd1, 16'hFFFF);
    wr(3'd4, 16'hFFFF);
    wr(3'd5, 16'h0000);
    wr(3'd7, 16'hFFFF);
    idle(1);
    chk("R9", "offset", int'(offset), 'h33);
    chk("R9", "gain", int'(gain), 'h50);
    chk("R9", "dmux", int'(dmux), 2);

    // R2 start with a simultaneous write (lands)
    @(negedge clk);
    cal_start = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'h0044;
    @(negedge clk);
    cal_start = 1'b0; wr_en = 1'b0;
    chk("R2", "busy after start", int'(cal_busy), 1);
    chk("R2", "write in start cycle", int'(offset), 'h44);
    chk("R4", "decim forced", int'(decim), 1);
    chk("R4", "dmux forced", int'(dmux), 0);
    chk("R4", "gray forced", int'(gray), 0);

    // R5 writes during calibration dropped
    wr(3'd0, 16'h0C1E);
    wr(3'd2, 16'h0011);
    wr(3'd3, 16'h0022);
    @(negedge clk);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    chk("R5", "offset", int'(offset), 'h44);
    chk("R5", "gain", int'(gain), 'h50);
    chk("R5", "manual", int'(manual), 1);
    chk("R2", "still busy", int'(cal_busy), 1);

    // R3 done with simultaneous write (dropped)
    @(negedge clk);
    cal_done = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'h00AA;
    @(negedge clk);
    cal_done = 1'b0; wr_en = 1'b0;
    chk("R3", "busy cleared", int'(cal_busy), 0);
    chk("R3", "dmux restored", int'(dmux), 2);
    chk("R3", "gray restored", int'(gray), 1);
    chk("R5", "done-cycle write dropped", int'(offset), 'h44);

    // done while idle has no effect
    @(negedge clk);
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    chk("R2", "done while idle", int'(cal_busy), 0);
    idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule